// File: doc/BRIEF.md
# Dithered Capture/Compare Channel

This block is one channel of a general-purpose timer. It owns a 20-bit programmable register that plays two roles. In output mode the register is the compare source. A write lands in a preload stage and reaches the active compare stage either at once or on the next update event. The active value is compared with the running timer count, and the channel output is high while the count is below the effective compare value. In input mode the register becomes a capture destination. A capture pulse latches the counter value into it, and software writes are dropped.

An optional dither mode splits the compare value into a 16-bit integer part and a 4-bit fraction. A 4-bit period index advances on every counter overflow. On exactly F of every 16 consecutive periods, where F is the fraction, the effective compare value is the integer part plus one. A bit-reversed index spreads those extended periods evenly. The counter, its overflow and the update event all come from outside the block.

Register writes arrive on a valid/ready interface. `wr_ready` drops only in a cycle where the channel is in input mode and a capture pulse is present. A write offered in that cycle is held back, not lost. The writer must keep `wr_valid` and `wr_data` steady until a cycle in which both valid and ready are high. Reads are plain and combinational.

Top module: `dither_cc_channel`

## Requirements
- R1: After reset the register reads zero, the active compare value is zero, the period index is zero and `oc_out` is low.
- R2: Bits 31:20 of `rd_data` always read as zero.
- R3: In output mode with dither off, an accepted write stores `wr_data[15:0]` and clears register bits 19:16. With dither on, it stores `wr_data[19:0]`.
- R4: With preload disabled, an accepted write reaches the active compare value at the same clock edge that updates the register.
- R5: With preload enabled, the active compare value changes only at an edge where `update_evt` is high. It then takes the register contents held before that edge.
- R6: In output mode `oc_out` is high exactly when `cnt_value` is below the effective compare value. In input mode `oc_out` is low.
- R7: With dither on, the period index advances by one at each edge with `cnt_overflow` high and is held at zero while dither is off. The effective compare value is active[19:4] plus one when the 4-bit bit-reverse of the index is less than active[3:0], and active[19:4] otherwise. With dither off it is active[15:0].
- R8: In input mode an accepted write leaves the register unchanged.
- R9: In input mode a capture pulse loads `{4'b0, cnt_value}` with dither off, or `{cnt_value, 4'b0}` with dither on, at the next edge.
- R10: `wr_ready` is low exactly in cycles where input mode and `capture_evt` are both high. Otherwise it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_input_mode | input | 1 | 1 selects capture (input) mode, 0 selects compare (output) mode |
| cfg_preload_en | input | 1 | 1 buffers writes until an update event |
| cfg_dither_en | input | 1 | 1 enables the 4-bit fractional dither |
| cnt_value | input | 16 | Running timer count |
| cnt_overflow | input | 1 | One-cycle pulse at each counter period end |
| update_evt | input | 1 | One-cycle update event pulse |
| capture_evt | input | 1 | One-cycle capture pulse |
| wr_valid | input | 1 | Register write offered |
| wr_ready | output | 1 | Register write can be taken this cycle |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register contents |
| oc_out | output | 1 | Compare output |

## Verification
The assertions assume that the three configuration inputs change only in cycles that carry no write, capture or update. They also assume that `cnt_overflow`, `update_evt` and `capture_evt` are single-cycle pulses aligned to the timer clock. The stimulus changes configuration only between idle cycles. It drives each event for exactly one cycle, right after a rising edge. When it offers a write during a capture, it holds that write until it is accepted.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic { CC_OUTPUT = 1'b0, CC_INPUT = 1'b1 } cc_mode_e;
endpackage

// File: rtl/cc_regfile.sv
module cc_regfile #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cc_pkg::cc_mode_e  mode,
  input  logic              preload_en,
  input  logic              dither_en,
  input  logic              wr_fire,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              update_evt,
  input  logic              capture_evt,
  input  logic [CNT_W-1:0]  cnt_value,
  output logic [REG_W-1:0]  prog_q,
  output logic [REG_W-1:0]  act_q
);
  logic [REG_W-1:0] wr_val, cap_val, prog_next;

  // write format depends on dither: integer-only values clear the top nibble
  always_comb begin
    wr_val  = dither_en ? wr_data : {{FRAC_W{1'b0}}, wr_data[CNT_W-1:0]};
    cap_val = dither_en ? {cnt_value, {FRAC_W{1'b0}}} : {{FRAC_W{1'b0}}, cnt_value};
  end

  always_comb begin
    prog_next = prog_q;
    if (mode == cc_pkg::CC_INPUT) begin
      if (capture_evt) prog_next = cap_val;
    end else if (wr_fire) begin
      prog_next = wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_q <= '0;
    else        prog_q <= prog_next;
  end

  // active stage: follows at once, or waits for the update event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (mode == cc_pkg::CC_OUTPUT) begin
      if (!preload_en)     act_q <= prog_next;
      else if (update_evt) act_q <= prog_q;
    end
  end
endmodule

// File: rtl/cc_dither_seq.sv
module cc_dither_seq #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dither_en,
  input  logic              cnt_overflow,
  input  logic [FRAC_W-1:0] frac,
  output logic [FRAC_W-1:0] idx_q,
  output logic              extend
);
  logic [FRAC_W-1:0] idx_rev;

  for (genvar b = 0; b < FRAC_W; b++) begin : g_rev
    assign idx_rev[b] = idx_q[FRAC_W-1-b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            idx_q <= '0;
    else if (!dither_en)   idx_q <= '0;
    else if (cnt_overflow) idx_q <= idx_q + 1'b1;
  end

  // bit-reversed index below the fraction: F hits spread over 2**FRAC_W periods
  assign extend = dither_en && (idx_rev < frac);
endmodule

// File: rtl/cc_compare.sv
module cc_compare #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  cc_pkg::cc_mode_e  mode,
  input  logic              dither_en,
  input  logic [REG_W-1:0]  act,
  input  logic              extend,
  input  logic [CNT_W-1:0]  cnt_value,
  output logic              oc_out
);
  logic [CNT_W:0] eff;

  always_comb begin
    if (dither_en) eff = {1'b0, act[REG_W-1:FRAC_W]} + {{CNT_W{1'b0}}, extend};
    else           eff = {1'b0, act[CNT_W-1:0]};
    oc_out = (mode == cc_pkg::CC_OUTPUT) && ({1'b0, cnt_value} < eff);
  end
endmodule

// File: rtl/dither_cc_channel.sv
module dither_cc_channel #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int BUS_W  = 32,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_input_mode,
  input  logic             cfg_preload_en,
  input  logic             cfg_dither_en,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             cnt_overflow,
  input  logic             update_evt,
  input  logic             capture_evt,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [BUS_W-1:0] wr_data,
  output logic [BUS_W-1:0] rd_data,
  output logic             oc_out
);
  cc_pkg::cc_mode_e  mode;
  logic              wr_fire, extend;
  logic [REG_W-1:0]  prog_q, act_q;
  logic [FRAC_W-1:0] idx_q;

  assign mode     = cfg_input_mode ? cc_pkg::CC_INPUT : cc_pkg::CC_OUTPUT;
  assign wr_ready = !((mode == cc_pkg::CC_INPUT) && capture_evt);
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_data  = {{(BUS_W-REG_W){1'b0}}, prog_q};

  cc_regfile #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .mode(mode), .preload_en(cfg_preload_en),
    .dither_en(cfg_dither_en), .wr_fire(wr_fire), .wr_data(wr_data[REG_W-1:0]),
    .update_evt(update_evt), .capture_evt(capture_evt), .cnt_value(cnt_value),
    .prog_q(prog_q), .act_q(act_q)
  );

  cc_dither_seq #(.FRAC_W(FRAC_W)) i_dither (
    .clk(clk), .rst_n(rst_n), .dither_en(cfg_dither_en), .cnt_overflow(cnt_overflow),
    .frac(act_q[FRAC_W-1:0]), .idx_q(idx_q), .extend(extend)
  );

  cc_compare #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) i_cmp (
    .mode(mode), .dither_en(cfg_dither_en), .act(act_q), .extend(extend),
    .cnt_value(cnt_value), .oc_out(oc_out)
  );
endmodule

// File: rtl/cc_channel_checker.sv
module cc_channel_checker #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int BUS_W  = 32,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_input_mode,
  input logic              cfg_preload_en,
  input logic              cfg_dither_en,
  input logic              cnt_overflow,
  input logic              update_evt,
  input logic              capture_evt,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [BUS_W-1:0]  rd_data,
  input logic              oc_out,
  input logic [REG_W-1:0]  act,
  input logic [FRAC_W-1:0] idx
);
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[BUS_W-1:REG_W] == '0);

  p_wr_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !cfg_input_mode && !cfg_dither_en) |=>
      (rd_data[REG_W-1:CNT_W] == '0));

  p_preload_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_preload_en && !update_evt) |=> $stable(act));

  p_input_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_input_mode |-> !oc_out);

  p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dither_en && cnt_overflow) |=> (idx == $past(idx) + 1'b1));

  p_input_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_input_mode && wr_valid && wr_ready && !capture_evt) |=> $stable(rd_data));

  p_capture_lsb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_input_mode && cfg_dither_en && capture_evt) |=> (rd_data[FRAC_W-1:0] == '0));

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready) |-> (cfg_input_mode && capture_evt));
endmodule

bind dither_cc_channel cc_channel_checker #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .BUS_W(BUS_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_input_mode(cfg_input_mode), .cfg_preload_en(cfg_preload_en),
  .cfg_dither_en(cfg_dither_en), .cnt_overflow(cnt_overflow), .update_evt(update_evt),
  .capture_evt(capture_evt), .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
  .oc_out(oc_out), .act(act_q), .idx(idx_q)
);

// File: tb/test_dither_cc_channel.sv
module test_dither_cc_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_input_mode = 1'b0, cfg_preload_en = 1'b0, cfg_dither_en = 1'b0;
  logic [15:0] cnt_value = '0;
  logic        cnt_overflow = 1'b0, update_evt = 1'b0, capture_evt = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        oc_out;

  int checks = 0, errors = 0;
  bit model_on = 1'b0;

  // reference model state
  logic [19:0] m_prog = '0, m_act = '0;
  int          m_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_cc_channel i_dither_cc_channel (
    .clk(clk), .rst_n(rst_n), .cfg_input_mode(cfg_input_mode), .cfg_preload_en(cfg_preload_en),
    .cfg_dither_en(cfg_dither_en), .cnt_value(cnt_value), .cnt_overflow(cnt_overflow),
    .update_evt(update_evt), .capture_evt(capture_evt), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_data(rd_data), .oc_out(oc_out)
  );

  function automatic int rev4(int v);
    int r = 0;
    for (int b = 0; b < 4; b++) if (v[b]) r |= 1 << (3 - b);
    return r;
  endfunction

  function automatic bit exp_oc();
    int eff;
    if (cfg_input_mode) return 1'b0;
    if (cfg_dither_en) eff = int'(m_act[19:4]) + ((rev4(m_idx) < int'(m_act[3:0])) ? 1 : 0);
    else               eff = int'(m_act[15:0]);
    return int'(cnt_value) < eff;
  endfunction

  task automatic check(string req, logic [31:0] act_v, logic [31:0] exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  // model step at each rising edge
  always @(posedge clk) begin
    logic [19:0] np, na;
    bit fire;
    if (!rst_n) begin
      m_prog = '0; m_act = '0; m_idx = 0;
    end else begin
      fire = wr_valid && !(cfg_input_mode && capture_evt);
      np = m_prog; na = m_act;
      if (cfg_input_mode) begin
        if (capture_evt) np = cfg_dither_en ? {cnt_value, 4'h0} : {4'h0, cnt_value};
      end else if (fire) begin
        np = cfg_dither_en ? wr_data[19:0] : {4'h0, wr_data[15:0]};
      end
      if (!cfg_input_mode) begin
        if (!cfg_preload_en) na = np;
        else if (update_evt) na = m_prog;
      end
      if (!cfg_dither_en)    m_idx = 0;
      else if (cnt_overflow) m_idx = (m_idx + 1) % 16;
      m_prog = np; m_act = na;
    end
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (model_on) begin
      check("R2/R3/R8/R9 rd_data", rd_data, {12'h0, m_prog});
      check("R6/R7 oc_out", {31'h0, oc_out}, {31'h0, exp_oc()});
      check("R10 wr_ready", {31'h0, wr_ready},
            {31'h0, !(cfg_input_mode && capture_evt)});
    end
  end

  task automatic step();
    @(posedge clk); #1;
    wr_valid = 1'b0; cnt_overflow = 1'b0; update_evt = 1'b0; capture_evt = 1'b0;
  endtask

  task automatic write(logic [31:0] d);
    wr_valid = 1'b1; wr_data = d;
    step();
  endtask

  task automatic dither_sweep(logic [19:0] val, int exp_hits);
    int hits = 0;
    write({12'h0, val});
    for (int p = 0; p < 16; p++) begin
      cnt_value = val[19:4];
      @(negedge clk);
      if (oc_out) hits++;
      cnt_overflow = 1'b1;
      step();
    end
    check("R7 extended periods", hits, exp_hits);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 oc_out", {31'h0, oc_out}, 32'h0);
    rst_n = 1'b1;
    step();
    model_on = 1'b1;

    // R3/R4: dither off, no preload; top nibble cleared, immediate effect
    write(32'hFFFF_1234);
    check("R3 masked write", rd_data, 32'h0000_1234);
    check("R2 upper zero", {20'h0, rd_data[31:20]}, 32'h0);
    cnt_value = 16'h1233; #1;
    check("R4 immediate compare high", {31'h0, oc_out}, 32'h1);
    cnt_value = 16'h1234; #1;
    check("R6 compare equal low", {31'h0, oc_out}, 32'h0);
    step();

    // R5: preload enabled, active waits for update
    cfg_preload_en = 1'b1; step();
    write(32'h0000_0500);
    cnt_value = 16'h0600; #1;
    check("R5 old value still active", {31'h0, oc_out}, 32'h1);
    step(); step();
    update_evt = 1'b1; step();
    check("R5 new value after update", {31'h0, oc_out}, 32'h0);
    cnt_value = 16'h04FF; step();
    cfg_preload_en = 1'b0; step();

    // R7: dither sweeps
    cfg_dither_en = 1'b1; step();
    write(32'hABCD_E123);
    check("R3 dither keeps 20 bits", rd_data, 32'h000D_E123);
    dither_sweep(20'h000A5, 5);
    dither_sweep(20'h0003F, 15);
    dither_sweep(20'h00070, 0);
    cfg_dither_en = 1'b0; step();

    // R8/R9/R10: input mode
    cfg_input_mode = 1'b1; step();
    check("R6 input mode low", {31'h0, oc_out}, 32'h0);
    cnt_value = 16'h1ABC; capture_evt = 1'b1; step();
    check("R9 capture no dither", rd_data, 32'h0000_1ABC);
    write(32'h0000_5555);
    check("R8 write ignored", rd_data, 32'h0000_1ABC);
    cfg_dither_en = 1'b1; step();
    cnt_value = 16'hF00D; capture_evt = 1'b1;
    wr_valid = 1'b1; wr_data = 32'h0000_7777; #1;
    check("R10 ready low on capture", {31'h0, wr_ready}, 32'h0);
    @(posedge clk); #1;
    capture_evt = 1'b0;
    check("R9 capture dither", rd_data, 32'h000F_00D0);
    step();
    check("R8 held write ignored", rd_data, 32'h000F_00D0);
    cfg_dither_en = 1'b0; cfg_input_mode = 1'b0; step();

    // mixed traffic, model compared every clock
    for (int i = 0; i < 400; i++) begin
      cnt_value = 16'((i * 37) % 700);
      if (i % 97 == 0) begin cfg_dither_en = ~cfg_dither_en; step(); end
      if (i % 53 == 0) begin cfg_preload_en = ~cfg_preload_en; step(); end
      if (i % 7 == 0) begin wr_valid = 1'b1; wr_data = 32'((i * 1237) & 32'hFFFFF); end
      if (i % 11 == 0) update_evt = 1'b1;
      if (i % 13 == 0) cnt_overflow = 1'b1;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule